// File: doc/BRIEF.md
# USB OUT Endpoint Buffer Controller

This block looks after a single USB OUT endpoint. It sits between the serial interface engine, which delivers received data packets, and a CPU register port. The engine marks each packet with a start strobe, then a run of valid bytes, then an end strobe. The end strobe carries a corruption flag and the DATA0/DATA1 PID bit. One cycle after the end strobe the block returns its handshake choice. Token decoding, CRC checking and the bit-level link are handled elsewhere.

Packets are kept in a packet FIFO of one or two slots. The CPU works through three registers: a low control/status register, a high configuration register and a byte-count register. It pulls bytes out through a FIFO read port, and an interrupt request line tells it when there is work. The block tracks the data toggle, honours stall requests, and reports isochronous data errors and overruns. It can also release a fully read maximum-size packet automatically.

Top module: `usb_out_ep`

## Requirements
- R1: After reset every register reads 0x00, `hsCode` is 0 (none) and `irq` is low.
- R2: `hsCode` encodes 0=none, 1=ACK, 2=NAK, 3=STALL and is valid for one cycle, the cycle after the end strobe. In bulk mode, a clean packet whose PID equals the expected toggle is stored and answered with ACK, and the expected toggle flips. Storing the packet sets packet-ready (low register bit 0). The count register (address 2) then gives its length, and the read port returns its bytes in arrival order. Bytes beyond `MAX_BYTES` are dropped, and the count stops at `MAX_BYTES`.
- R3: A clean bulk packet whose PID differs from the expected toggle is answered with ACK but is not stored, and the expected toggle keeps its value.
- R4: Writing 1 to low register bit 7 sets the expected toggle to DATA0. Bit 7 always reads 0.
- R5: While the stall-request bit (low bit 5, read/write) is set in bulk mode, a received packet gets a STALL handshake and is not stored. Each STALL sets stall-sent (low bit 6). Writing 0 to stall-sent clears it, and writing 1 leaves it unchanged.
- R6: In isochronous mode (high register bit 6 = 1) the stall-request bit has no effect: packets are stored and no STALL is sent.
- R7: Writing 1 to low bit 4 discards the head packet. With two packets stored, two such writes empty the FIFO.
- R8: FIFO-full (low bit 1) is set when one packet is stored with double buffering off, or two with it on. A bulk packet that arrives while the FIFO is full gets NAK, is dropped, and leaves the toggle unchanged.
- R9: With double buffering on (high bit 0 = 1) two packets can be held. Writing 0 to low bit 0 releases the head. Packet-ready then stays set and the second packet's length and bytes become visible. Writing 1 to bit 0 has no effect.
- R10: In isochronous mode no handshake is ever returned. A packet flagged as corrupted is still stored, and data-error (low bit 3) is set while it is at the head. The flag clears when that packet is released.
- R11: In isochronous mode a packet that arrives while the FIFO is full is dropped and sets overrun (low bit 2). Writing 0 to overrun clears it, and writing 1 leaves it unchanged.
- R12: With auto-clear on (high bit 7 = 1), reading the `maxPktSize`-th byte of the head packet releases it. A shorter read leaves packet-ready set.
- R13: `irq` is high exactly when `irqEn` is high and either packet-ready or stall-sent is set.
- R14: A bulk packet flagged as corrupted gets no handshake, is not stored, and leaves the toggle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxStart | input | 1 | Engine: start of a received data packet |
| rxValid | input | 1 | Engine: `rxData` holds a payload byte |
| rxData | input | 8 | Engine: payload byte |
| rxEnd | input | 1 | Engine: end of packet, one cycle after the last byte at the earliest |
| rxErr | input | 1 | Engine: packet corrupted (CRC or bit-stuff), valid with `rxEnd` |
| rxPid | input | 1 | Engine: data PID, 0=DATA0, 1=DATA1, valid with `rxEnd` |
| hsCode | output | 2 | Handshake choice: 0 none, 1 ACK, 2 NAK, 3 STALL |
| regWr | input | 1 | CPU register write strobe |
| regAddr | input | 2 | Register select: 0 low control/status, 1 high config, 2 byte count |
| regWdata | input | 8 | CPU write data |
| regRdata | output | 8 | CPU read data for `regAddr` |
| fifoRd | input | 1 | CPU: consume the byte on `fifoData` |
| fifoData | output | 8 | Current byte of the head packet |
| maxPktSize | input | CNT_W | Maximum packet size used by auto-clear |
| irqEn | input | 1 | Endpoint interrupt enable |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench builds the block with `MAX_BYTES` set to 8 and drives `maxPktSize` to 4. With an 8-byte slot, a 10-byte packet reaches the truncation path, where the count saturates and the extra bytes are dropped. The small maximum size lets auto-clear fire after a few reads, and lets a shorter read be shown to leave the packet in place. Double buffering is switched on during the run, so single-slot full and two-slot full both occur. That brings both NAK conditions and the isochronous overrun within reach.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hsCode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_STORE,
    RX_FULL,
    RX_STALL
  } rxMode_e;

  localparam logic [1:0] REG_CS_LO = 2'd0;
  localparam logic [1:0] REG_CS_HI = 2'd1;
  localparam logic [1:0] REG_COUNT = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic pktStart;
    logic byteWr;
    logic commit;
    logic commitErr;
    logic pop;
    logic rdStep;
  } dpStrobe_t;

endpackage

// File: rtl/usb_out_ep_dp.sv
module usb_out_ep_dp
  import usb_out_ep_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [7:0]       wrData,
  output logic [1:0]       pktCount,
  output logic [CNT_W-1:0] headLen,
  output logic             headErr,
  output logic [CNT_W-1:0] rdIdx,
  output logic [7:0]       rdData
);

  localparam int ADDR_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

  logic             wrSlot;
  logic             rdSlot;
  logic [CNT_W-1:0] wrIdx;
  logic [CNT_W-1:0] slotLen [2];
  logic             slotErr [2];
  logic [7:0]       slotByte [2];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [7:0]       mem [MAX_BYTES];
    logic [CNT_W-1:0] lenQ;
    logic             errQ;

    always_ff @(posedge clk) begin
      if (stb.byteWr && wrSlot == 1'(s) && wrIdx < CAP)
        mem[wrIdx[ADDR_W-1:0]] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenQ <= '0;
        errQ <= 1'b0;
      end else if (stb.commit && wrSlot == 1'(s)) begin
        lenQ <= wrIdx;
        errQ <= stb.commitErr;
      end
    end

    assign slotLen[s]  = lenQ;
    assign slotErr[s]  = errQ;
    assign slotByte[s] = mem[rdIdx[ADDR_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      wrSlot   <= 1'b0;
      rdSlot   <= 1'b0;
      rdIdx    <= '0;
      pktCount <= 2'd0;
    end else begin
      if (stb.pktStart)
        wrIdx <= '0;
      else if (stb.byteWr && wrIdx < CAP)
        wrIdx <= wrIdx + 1'b1;

      if (stb.commit) wrSlot <= ~wrSlot;

      if (stb.pop) begin
        rdSlot <= ~rdSlot;
        rdIdx  <= '0;
      end else if (stb.rdStep) begin
        rdIdx <= rdIdx + 1'b1;
      end

      case ({stb.commit, stb.pop})
        2'b10:   pktCount <= pktCount + 2'd1;
        2'b01:   pktCount <= pktCount - 2'd1;
        default: pktCount <= pktCount;
      endcase
    end
  end

  always_comb begin
    headLen = (pktCount != 2'd0) ? slotLen[rdSlot] : '0;
    headErr = (pktCount != 2'd0) && slotErr[rdSlot];
    rdData  = slotByte[rdSlot];
  end

  // R9: never more than two packets held
  p_count_max_r9: assert property (@(posedge clk) disable iff (!rstN)
    pktCount <= 2'd2);

  // R8: a third packet is never committed
  p_no_commit_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && pktCount == 2'd2) |-> stb.pop);

  // R7: release only with a packet present
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> pktCount != 2'd0);

  // R2: reads stay inside the head packet
  p_rd_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStep |-> rdIdx < headLen);

endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxStart,
  input  logic             rxValid,
  input  logic             rxEnd,
  input  logic             rxErr,
  input  logic             rxPid,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  input  logic             fifoRd,
  input  logic [CNT_W-1:0] maxPktSize,
  input  logic             irqEn,
  input  logic [1:0]       pktCount,
  input  logic [CNT_W-1:0] headLen,
  input  logic             headErr,
  input  logic [CNT_W-1:0] rdIdx,
  output dpStrobe_t        stb,
  output logic [1:0]       hsCode,
  output logic [7:0]       csLow,
  output logic [7:0]       csHigh,
  output logic             irq
);

  logic    expToggle, stallReq, stallSent, overrun;
  logic    autoClr, isoMode, dblBuf;
  rxMode_e rxMode;
  hsCode_e hsNext, hsReg;

  logic wrLow, wrHigh, pktReady, fifoFull, stallActive, endEvt;
  logic autoPop, cpuPop;

  always_comb begin
    wrLow       = regWr && regAddr == REG_CS_LO;
    wrHigh      = regWr && regAddr == REG_CS_HI;
    pktReady    = pktCount != 2'd0;
    fifoFull    = dblBuf ? (pktCount == 2'd2) : pktReady;
    stallActive = stallReq && !isoMode;
    endEvt      = rxEnd && rxMode != RX_IDLE;

    hsNext = HS_NONE;
    if (endEvt && !isoMode) begin
      case (rxMode)
        RX_STALL: hsNext = HS_STALL;
        RX_FULL:  hsNext = HS_NAK;
        RX_STORE: hsNext = rxErr ? HS_NONE : HS_ACK;
        default:  hsNext = HS_NONE;
      endcase
    end

    stb.pktStart  = rxStart;
    stb.byteWr    = rxValid && rxMode == RX_STORE;
    stb.commit    = endEvt && rxMode == RX_STORE &&
                    (isoMode || (!rxErr && rxPid == expToggle));
    stb.commitErr = rxErr;
    stb.rdStep    = fifoRd && pktReady && (rdIdx < headLen);
    autoPop       = autoClr && stb.rdStep &&
                    (CNT_W'(rdIdx + 1'b1) == maxPktSize);
    cpuPop        = wrLow && (regWdata[4] || !regWdata[0]);
    stb.pop       = pktReady && (cpuPop || autoPop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expToggle <= 1'b0;
      stallReq  <= 1'b0;
      stallSent <= 1'b0;
      overrun   <= 1'b0;
      autoClr   <= 1'b0;
      isoMode   <= 1'b0;
      dblBuf    <= 1'b0;
      rxMode    <= RX_IDLE;
      hsReg     <= HS_NONE;
    end else begin
      hsReg <= hsNext;

      if (rxStart)
        rxMode <= stallActive ? RX_STALL : (fifoFull ? RX_FULL : RX_STORE);
      else if (rxEnd)
        rxMode <= RX_IDLE;

      if (wrLow && regWdata[7])
        expToggle <= 1'b0;
      else if (stb.commit && !isoMode)
        expToggle <= ~expToggle;

      if (wrLow) stallReq <= regWdata[5];

      if (hsNext == HS_STALL)
        stallSent <= 1'b1;
      else if (wrLow && !regWdata[6])
        stallSent <= 1'b0;

      if (endEvt && isoMode && rxMode == RX_FULL)
        overrun <= 1'b1;
      else if (wrLow && !regWdata[2])
        overrun <= 1'b0;

      if (wrHigh) begin
        autoClr <= regWdata[7];
        isoMode <= regWdata[6];
        dblBuf  <= regWdata[0];
      end
    end
  end

  assign hsCode = hsReg;
  assign csLow  = {1'b0, stallSent, stallReq, 1'b0,
                   pktReady && headErr, overrun, fifoFull, pktReady};
  assign csHigh = {autoClr, isoMode, 5'b0, dblBuf};
  assign irq    = irqEn && (pktReady || stallSent);

  // R5: a STALL leaves stall-sent raised
  p_stall_marks_sent_r5: assert property (@(posedge clk) disable iff (!rstN)
    hsReg == HS_STALL |-> stallSent);

  // R10: isochronous packets never get a handshake
  p_iso_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    hsReg != HS_NONE |-> !$past(isoMode));

  // R4: a toggle-clear write leaves DATA0 expected
  p_toggle_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrLow && regWdata[7]) |-> !expToggle);

  // R2: handshake is a one-cycle pulse
  p_hs_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    hsReg != HS_NONE |=> hsReg == HS_NONE);

endmodule

// File: rtl/usb_out_ep.sv
module usb_out_ep
  import usb_out_ep_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxStart,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxEnd,
  input  logic             rxErr,
  input  logic             rxPid,
  output logic [1:0]       hsCode,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             fifoRd,
  output logic [7:0]       fifoData,
  input  logic [CNT_W-1:0] maxPktSize,
  input  logic             irqEn,
  output logic             irq
);

  dpStrobe_t        stb;
  logic [1:0]       pktCount;
  logic [CNT_W-1:0] headLen;
  logic [CNT_W-1:0] rdIdx;
  logic             headErr;
  logic [7:0]       csLow, csHigh;

  usb_out_ep_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxStart(rxStart), .rxValid(rxValid), .rxEnd(rxEnd),
    .rxErr(rxErr), .rxPid(rxPid),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .fifoRd(fifoRd), .maxPktSize(maxPktSize), .irqEn(irqEn),
    .pktCount(pktCount), .headLen(headLen), .headErr(headErr), .rdIdx(rdIdx),
    .stb(stb), .hsCode(hsCode), .csLow(csLow), .csHigh(csHigh), .irq(irq)
  );

  usb_out_ep_dp #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(rxData),
    .pktCount(pktCount), .headLen(headLen), .headErr(headErr),
    .rdIdx(rdIdx), .rdData(fifoData)
  );

  always_comb begin
    case (regAddr)
      REG_CS_LO: regRdata = csLow;
      REG_CS_HI: regRdata = csHigh;
      REG_COUNT: regRdata = 8'(headLen);
      default:   regRdata = 8'h00;
    endcase
  end

endmodule

// File: tb/usb_out_ep_tb_top.sv
module usb_out_ep_tb_top;

  localparam int MB = 8;
  localparam int CW = $clog2(MB + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxStart = 0, rxValid = 0, rxEnd = 0, rxErr = 0, rxPid = 0;
  logic [7:0]    rxData = '0;
  logic [1:0]    hsCode;
  logic          regWr = 0;
  logic [1:0]    regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          fifoRd = 0;
  logic [7:0]    fifoData;
  logic [CW-1:0] maxPktSize = CW'(4);
  logic          irqEn = 0;
  logic          irq;

  int nChk = 0;
  int nFail = 0;
  int hsQ[$];
  string hsTagQ[$];
  int dataQ[$];

  always #5 clk = ~clk;

  usb_out_ep #(.MAX_BYTES(MB)) dut_i (
    .clk(clk), .rstN(rstN),
    .rxStart(rxStart), .rxValid(rxValid), .rxData(rxData),
    .rxEnd(rxEnd), .rxErr(rxErr), .rxPid(rxPid), .hsCode(hsCode),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .fifoRd(fifoRd), .fifoData(fifoData), .maxPktSize(maxPktSize),
    .irqEn(irqEn), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected handshakes and read bytes
  initial forever begin
    @(negedge clk);
    #3;
    if (hsCode != 2'd0) begin
      if (hsQ.size() == 0) chk("R2 unexpected handshake", hsCode, 0);
      else chk(hsTagQ.pop_front(), hsCode, hsQ.pop_front());
    end
    if (fifoRd) begin
      if (dataQ.size() == 0) chk("R2 unexpected read", fifoData, 0);
      else chk("R2 fifo byte", fifoData, dataQ.pop_front());
    end
  end

  task automatic sendPkt(bit pid, int len, bit err, int seed, int expHs, string tag);
    if (expHs != 0) begin
      hsQ.push_back(expHs);
      hsTagQ.push_back(tag);
    end
    @(negedge clk); rxStart = 1;
    @(negedge clk); rxStart = 0;
    for (int i = 0; i < len; i++) begin
      rxValid = 1; rxData = 8'(seed * 16 + i);
      @(negedge clk);
    end
    rxValid = 0; rxEnd = 1; rxErr = err; rxPid = pid;
    @(negedge clk); rxEnd = 0; rxErr = 0;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " pending handshakes"}, hsQ.size(), 0);
    hsQ.delete();
    hsTagQ.delete();
  endtask

  task automatic readPkt(int seed, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dataQ.push_back(seed * 16 + i);
      fifoRd = 1;
    end
    @(negedge clk); fifoRd = 0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdChk(logic [1:0] a, int exp, string tag);
    @(negedge clk); regAddr = a;
    #3;
    chk(tag, regRdata, exp);
  endtask

  task automatic irqChk(int exp, string tag);
    @(negedge clk);
    #3;
    chk(tag, irq, exp);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdChk(2'd0, 8'h00, "R1 low reset");
    rdChk(2'd1, 8'h00, "R1 high reset");
    rdChk(2'd2, 8'h00, "R1 count reset");
    chk("R1 hsCode reset", hsCode, 0);
    chk("R1 irq reset", irq, 0);
    irqEn = 1;

    // R2 good bulk packet, toggle 0 -> 1
    sendPkt(0, 5, 0, 1, 1, "R2 ack");
    rdChk(2'd0, 8'h03, "R2 ready and R8 full");
    rdChk(2'd2, 5, "R2 count");
    irqChk(1, "R13 irq on ready");
    readPkt(1, 5);
    wrReg(2'd0, 8'h00);
    rdChk(2'd0, 8'h00, "R9 release");
    irqChk(0, "R13 irq low");

    // R3 mismatch, then truncated good packet
    sendPkt(0, 3, 0, 9, 1, "R3 ack on mismatch");
    rdChk(2'd0, 8'h00, "R3 not stored");
    sendPkt(1, 10, 0, 2, 1, "R2 long ack");
    rdChk(2'd2, 8, "R2 count capped");
    readPkt(2, 8);
    wrReg(2'd0, 8'h00);

    // R4 toggle clear
    sendPkt(0, 1, 0, 3, 1, "R4 setup ack");
    wrReg(2'd0, 8'h00);
    wrReg(2'd0, 8'h80);
    rdChk(2'd0, 8'h00, "R4 bit reads 0");
    sendPkt(0, 4, 0, 3, 1, "R4 data0 ack");
    rdChk(2'd2, 4, "R4 data0 stored");
    wrReg(2'd0, 8'h00);

    // R8 full and NAK, single buffer
    sendPkt(1, 2, 0, 4, 1, "R8 ack");
    sendPkt(0, 3, 0, 5, 2, "R8 nak");
    rdChk(2'd2, 2, "R8 count kept");
    rdChk(2'd0, 8'h03, "R8 full");
    wrReg(2'd0, 8'h00);
    sendPkt(0, 1, 0, 5, 1, "R8 toggle kept ack");
    rdChk(2'd2, 1, "R8 toggle kept stored");
    wrReg(2'd0, 8'h00);

    // R14 corrupted bulk packet
    sendPkt(1, 3, 1, 6, 0, "R14 silent");
    rdChk(2'd0, 8'h00, "R14 not stored");
    sendPkt(1, 2, 0, 6, 1, "R14 toggle kept ack");
    rdChk(2'd2, 2, "R14 toggle kept stored");
    wrReg(2'd0, 8'h00);

    // R5 stall
    wrReg(2'd0, 8'h20);
    rdChk(2'd0, 8'h20, "R5 stall request");
    sendPkt(0, 2, 0, 7, 3, "R5 stall");
    rdChk(2'd0, 8'h60, "R5 stall sent");
    irqChk(1, "R13 irq on stall sent");
    wrReg(2'd0, 8'h41);
    rdChk(2'd0, 8'h40, "R5 sent kept on write 1");
    wrReg(2'd0, 8'h01);
    rdChk(2'd0, 8'h00, "R5 sent cleared");
    irqChk(0, "R13 irq low after stall");
    sendPkt(0, 3, 0, 7, 1, "R5 after stall ack");
    rdChk(2'd2, 3, "R5 after stall stored");
    wrReg(2'd0, 8'h00);

    // R9 / R7 double buffering
    wrReg(2'd1, 8'h01);
    rdChk(2'd1, 8'h01, "R9 high reg");
    sendPkt(1, 3, 0, 6, 1, "R9 first ack");
    rdChk(2'd0, 8'h01, "R9 not full");
    sendPkt(0, 2, 0, 7, 1, "R9 second ack");
    rdChk(2'd0, 8'h03, "R8 two slots full");
    rdChk(2'd2, 3, "R9 head count");
    wrReg(2'd0, 8'h11);
    rdChk(2'd2, 2, "R7 first flush");
    rdChk(2'd0, 8'h01, "R7 one left");
    wrReg(2'd0, 8'h11);
    rdChk(2'd0, 8'h00, "R7 empty");
    sendPkt(1, 4, 0, 8, 1, "R9 third ack");
    sendPkt(0, 2, 0, 9, 1, "R9 fourth ack");
    wrReg(2'd0, 8'h00);
    rdChk(2'd0, 8'h01, "R9 ready stays");
    rdChk(2'd2, 2, "R9 promoted count");
    readPkt(9, 2);
    sendPkt(1, 1, 0, 10, 1, "R9 refill ack");
    sendPkt(0, 1, 0, 11, 2, "R8 nak double");
    wrReg(2'd0, 8'h00);
    wrReg(2'd0, 8'h00);
    rdChk(2'd0, 8'h00, "R9 drained");

    // R12 auto-clear
    wrReg(2'd1, 8'h81);
    sendPkt(0, 4, 0, 10, 1, "R12 ack");
    readPkt(10, 4);
    rdChk(2'd0, 8'h00, "R12 auto release");
    sendPkt(1, 3, 0, 11, 1, "R12 short ack");
    readPkt(11, 3);
    rdChk(2'd0, 8'h01, "R12 short kept");
    wrReg(2'd0, 8'h00);

    // R6 / R10 / R11 isochronous
    wrReg(2'd1, 8'h40);
    wrReg(2'd0, 8'h21);
    rdChk(2'd0, 8'h20, "R9 write 1 no effect when empty");
    sendPkt(0, 2, 1, 12, 0, "R6 R10 iso no stall");
    rdChk(2'd0, 8'h2B, "R10 error stored");
    rdChk(2'd2, 2, "R10 count");
    sendPkt(1, 1, 0, 13, 0, "R11 iso overrun");
    rdChk(2'd0, 8'h2F, "R11 overrun set");
    wrReg(2'd0, 8'h2B);
    rdChk(2'd0, 8'h2B, "R11 overrun cleared");
    wrReg(2'd0, 8'h20);
    rdChk(2'd0, 8'h20, "R10 error clears with ready");
    wrReg(2'd0, 8'h00);
    rdChk(2'd0, 8'h00, "R5 stall request cleared");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule